// File: doc/BRIEF.md
# Indexed Single-Pin GPIO Attribute Writer

This block is a write-only indexed port into the per-bank configuration state of a banked GPIO controller. Software writes one 32-bit command word to a fixed index address. The word names one pin and one attribute class. The block changes only that pin's bit, or that pin's 8-pin group bit, in the selected per-bank register. All other pins keep their values. Each bank of 32 pins holds the following registers: output data, direction, interrupt enable, three interrupt sensitivity selects, interrupt status, two debounce selects, reset tolerance, two command-source selects and input mask. Two parameter masks per bank say which pins can act as inputs and which can drive outputs. These masks constrain the data, direction and input-mask writes.

A per-pin event input sets interrupt status bits when the pin's interrupt is enabled. A pending counter tracks how many status bits are set, and an interrupt output is high while that counter is nonzero. A malformed command raises a one-cycle error pulse. Every register is exposed as a flat output vector so the surrounding controller can use the state.

Top module: `gpio_idx_writer`

## Requirements
- R1: Only a write with `wr_addr_i` equal to IDX_ADDR (default byte offset 0x2AC) is decoded. A write to any other address changes no register and gives no error.
- R2: Command word fields: pin number in bits 7:0, command bit at 12, attribute type in bits 19:16, values from bit 20 upward. The bank is the pin number / 32, the pin within the bank is the pin number mod 32, and the group is (pin mod 32) / 8. Register bit index = bank*32 + pin.
- R3: Type 0 (data) puts bit 20 into the pin's data bit, then ANDs the bank's data register with its output-capable mask.
- R4: Type 1 (direction) puts bit 20 into the pin's direction bit, then sets the bank's direction to (dir OR NOT input_capable) AND output_capable.
- R5: Type 2 (interrupt) loads the pin's interrupt enable from bit 20 and its sensitivity selects 0, 1 and 2 from bits 21, 22 and 23.
- R6: In a type 2 write, bit 24 = 1 clears the pin's status bit. The pending counter drops by one only if that bit was set, and it never goes below zero.
- R7: Type 3 (debounce) loads debounce selects 1 and 2 from bits 20 and 21. Type 4 (reset tolerance) loads the tolerance bit from bit 20.
- R8: Type 6 (input mask) loads bit 20 ANDed with the pin's input-capable mask bit.
- R9: Type 5 (command source) loads source selects 0 and 1 from bits 20 and 21 at bit 8*group of the bank, not at the pin position.
- R10: Types 7 to 15 change no state and raise `err_o` for exactly the cycle after the write.
- R11: A command bit of 1 raises `err_o` for one cycle, and the write is still applied.
- R12: A pin number whose bank is NBANK or above changes no state and raises `err_o` for one cycle.
- R13: A pulse on `int_set_i` sets each status bit whose interrupt is enabled and that is not already set. The pending counter rises by the number of bits newly set. `irq_o` is 1 exactly while the counter is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 32 | Command word |
| int_set_i | input | NBANK*32 | Per-pin interrupt event |
| data_o | output | NBANK*32 | Output data registers |
| dir_o | output | NBANK*32 | Direction registers |
| int_en_o | output | NBANK*32 | Interrupt enables |
| sens0_o | output | NBANK*32 | Sensitivity select 0 |
| sens1_o | output | NBANK*32 | Sensitivity select 1 |
| sens2_o | output | NBANK*32 | Sensitivity select 2 |
| status_o | output | NBANK*32 | Interrupt status |
| deb1_o | output | NBANK*32 | Debounce select 1 |
| deb2_o | output | NBANK*32 | Debounce select 2 |
| tol_o | output | NBANK*32 | Reset tolerance |
| src0_o | output | NBANK*32 | Command source select 0 |
| src1_o | output | NBANK*32 | Command source select 1 |
| imask_o | output | NBANK*32 | Input mask |
| pending_o | output | CNT_W | Pending interrupt count |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bench sweeps every pin of both banks through every valid type with several value patterns and compares all register vectors with a bench model after each write. The default masks contain bidirectional, input-only, output-only and absent pins. A design that writes the whole word, or skips the capability masks, would leak bits into neighbouring pins or leave output-only pins undriven. A design that puts the source selects at the pin position would show them off the group bases. A status clear on an unset bit must leave the pending counter unchanged; a naive decrement would lower it or wrap it. Out-of-range pin numbers, types 7 to 15, the command bit and foreign addresses are also swept. A design that aliases banks, decodes the reserved type, or accepts a non-index address would change state there.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;
  localparam int BANK_W   = 32;
  localparam int NUM_LSB  = 0;
  localparam int NUM_W    = 8;
  localparam int CMD_BIT  = 12;
  localparam int TYPE_LSB = 16;
  localparam int TYPE_W   = 4;
  localparam int VAL_LSB  = 20;
  localparam int VAL_W    = 5;

  typedef enum logic [TYPE_W-1:0] {
    ATTR_DATA = 4'd0,
    ATTR_DIR  = 4'd1,
    ATTR_IRQ  = 4'd2,
    ATTR_DEB  = 4'd3,
    ATTR_TOL  = 4'd4,
    ATTR_SRC  = 4'd5,
    ATTR_MASK = 4'd6
  } attr_e;

  typedef struct packed {
    logic [BANK_W-1:0] data;
    logic [BANK_W-1:0] dir;
    logic [BANK_W-1:0] int_en;
    logic [BANK_W-1:0] sens0;
    logic [BANK_W-1:0] sens1;
    logic [BANK_W-1:0] sens2;
    logic [BANK_W-1:0] status;
    logic [BANK_W-1:0] deb1;
    logic [BANK_W-1:0] deb2;
    logic [BANK_W-1:0] tol;
    logic [BANK_W-1:0] src0;
    logic [BANK_W-1:0] src1;
    logic [BANK_W-1:0] imask;
  } bank_regs_t;

  function automatic logic [BANK_W-1:0] put_bit(input logic [BANK_W-1:0] old,
                                                input logic [BANK_W-1:0] sel,
                                                input logic v);
    return v ? (old | sel) : (old & ~sel);
  endfunction
endpackage

// File: rtl/gpio_idx_decode.sv
module gpio_idx_decode
  import gpio_idx_pkg::*;
#(
  parameter int          NBANK    = 2,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] IDX_ADDR = 12'h2AC
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [NBANK-1:0]  sel_o,
  output logic [4:0]        pin_o,
  output logic [1:0]        grp_o,
  output attr_e             type_o,
  output logic [VAL_W-1:0]  vals_o,
  output logic              err_o
);
  logic             hit, type_ok, bank_ok, cmd_bad;
  logic [NUM_W-1:0] num;
  logic [2:0]       bank;
  logic [TYPE_W-1:0] typ;

  assign hit     = wr_en_i && (wr_addr_i == ADDR_W'(IDX_ADDR));
  assign num     = wr_data_i[NUM_LSB +: NUM_W];
  assign bank    = num[7:5];
  assign pin_o   = num[4:0];
  assign grp_o   = num[4:3];
  assign typ     = wr_data_i[TYPE_LSB +: TYPE_W];
  assign type_o  = attr_e'(typ);
  assign vals_o  = wr_data_i[VAL_LSB +: VAL_W];
  assign cmd_bad = wr_data_i[CMD_BIT];
  assign type_ok = typ <= 4'd6;
  assign bank_ok = 32'(bank) < NBANK;
  assign err_o   = hit && (!type_ok || !bank_ok || cmd_bad);

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    assign sel_o[b] = hit && type_ok && (32'(bank) == b);
  end
endmodule

// File: rtl/gpio_idx_bank.sv
module gpio_idx_bank
  import gpio_idx_pkg::*;
#(
  parameter logic [31:0] IN_CAP  = 32'hFFFF_FFFF,
  parameter logic [31:0] OUT_CAP = 32'hFFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  attr_e            type_i,
  input  logic [4:0]       pin_i,
  input  logic [1:0]       grp_i,
  input  logic [VAL_W-1:0] vals_i,
  input  logic [31:0]      int_set_i,
  output bank_regs_t       regs_o,
  output logic [31:0]      set_o,
  output logic [31:0]      clr_o
);
  bank_regs_t  q, n;
  logic [31:0] pbit, gbit, new_set, clr;

  assign pbit    = 32'd1 << pin_i;
  assign gbit    = 32'd1 << {grp_i, 3'b000};
  assign new_set = int_set_i & q.int_en & ~q.status;

  always_comb begin
    n   = q;
    clr = '0;
    if (wr_i) begin
      unique case (type_i)
        ATTR_DATA: n.data = put_bit(q.data, pbit, vals_i[0]) & OUT_CAP;
        ATTR_DIR:  n.dir  = (put_bit(q.dir, pbit, vals_i[0]) | ~IN_CAP) & OUT_CAP;
        ATTR_IRQ: begin
          n.int_en = put_bit(q.int_en, pbit, vals_i[0]);
          n.sens0  = put_bit(q.sens0, pbit, vals_i[1]);
          n.sens1  = put_bit(q.sens1, pbit, vals_i[2]);
          n.sens2  = put_bit(q.sens2, pbit, vals_i[3]);
          clr      = pbit & {32{vals_i[4]}} & q.status;
        end
        ATTR_DEB: begin
          n.deb1 = put_bit(q.deb1, pbit, vals_i[0]);
          n.deb2 = put_bit(q.deb2, pbit, vals_i[1]);
        end
        ATTR_TOL:  n.tol   = put_bit(q.tol, pbit, vals_i[0]);
        ATTR_SRC: begin
          n.src0 = put_bit(q.src0, gbit, vals_i[0]);
          n.src1 = put_bit(q.src1, gbit, vals_i[1]);
        end
        ATTR_MASK: n.imask = put_bit(q.imask, pbit, vals_i[0]) & IN_CAP;
        default: ;
      endcase
    end
    // set and clear are disjoint: new_set only touches bits not yet set
    n.status = (q.status & ~clr) | new_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= n;
  end

  assign regs_o = q;
  assign set_o  = new_set;
  assign clr_o  = clr;
endmodule

// File: rtl/gpio_idx_pending.sv
module gpio_idx_pending #(
  parameter int NPIN  = 64,
  parameter int CNT_W = $clog2(NPIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPIN-1:0]  set_i,
  input  logic [NPIN-1:0]  clr_i,
  output logic [CNT_W-1:0] pending_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   n_set, n_clr, sum;

  always_comb begin
    n_set = '0;
    n_clr = '0;
    for (int i = 0; i < NPIN; i++) begin
      n_set = n_set + (CNT_W+1)'(set_i[i]);
      n_clr = n_clr + (CNT_W+1)'(clr_i[i]);
    end
    sum = (CNT_W+1)'(cnt_q) + n_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (n_clr >= sum)  cnt_q <= '0;
    else                    cnt_q <= CNT_W'(sum - n_clr);
  end

  assign pending_o = cnt_q;
  assign irq_o     = |cnt_q;
endmodule

// File: rtl/gpio_idx_writer.sv
module gpio_idx_writer
  import gpio_idx_pkg::*;
#(
  parameter int                  NBANK    = 2,
  parameter int                  ADDR_W   = 12,
  parameter logic [11:0]         IDX_ADDR = 12'h2AC,
  parameter logic [NBANK*32-1:0] IN_CAP   = {32'h00FF_FFFF, 32'hFFFF_FF0F},
  parameter logic [NBANK*32-1:0] OUT_CAP  = {32'h0F0F_FFFF, 32'hFFFF_F0FF},
  localparam int                 NPIN     = NBANK * 32,
  localparam int                 CNT_W    = $clog2(NPIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NPIN-1:0]   int_set_i,
  output logic [NPIN-1:0]   data_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   int_en_o,
  output logic [NPIN-1:0]   sens0_o,
  output logic [NPIN-1:0]   sens1_o,
  output logic [NPIN-1:0]   sens2_o,
  output logic [NPIN-1:0]   status_o,
  output logic [NPIN-1:0]   deb1_o,
  output logic [NPIN-1:0]   deb2_o,
  output logic [NPIN-1:0]   tol_o,
  output logic [NPIN-1:0]   src0_o,
  output logic [NPIN-1:0]   src1_o,
  output logic [NPIN-1:0]   imask_o,
  output logic [CNT_W-1:0]  pending_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [NBANK-1:0] sel;
  logic [4:0]       pin;
  logic [1:0]       grp;
  attr_e            typ;
  logic [VAL_W-1:0] vals;
  logic             dec_err, err_q;
  logic [NPIN-1:0]  set_all, clr_all;

  gpio_idx_decode #(.NBANK(NBANK), .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR)) u_dec (
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .sel_o(sel), .pin_o(pin), .grp_o(grp), .type_o(typ), .vals_o(vals), .err_o(dec_err)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_regs_t r;
    gpio_idx_bank #(.IN_CAP(IN_CAP[b*32 +: 32]), .OUT_CAP(OUT_CAP[b*32 +: 32])) u_bank (
      .clk_i, .rst_ni,
      .wr_i(sel[b]), .type_i(typ), .pin_i(pin), .grp_i(grp), .vals_i(vals),
      .int_set_i(int_set_i[b*32 +: 32]),
      .regs_o(r), .set_o(set_all[b*32 +: 32]), .clr_o(clr_all[b*32 +: 32])
    );
    assign data_o[b*32 +: 32]   = r.data;
    assign dir_o[b*32 +: 32]    = r.dir;
    assign int_en_o[b*32 +: 32] = r.int_en;
    assign sens0_o[b*32 +: 32]  = r.sens0;
    assign sens1_o[b*32 +: 32]  = r.sens1;
    assign sens2_o[b*32 +: 32]  = r.sens2;
    assign status_o[b*32 +: 32] = r.status;
    assign deb1_o[b*32 +: 32]   = r.deb1;
    assign deb2_o[b*32 +: 32]   = r.deb2;
    assign tol_o[b*32 +: 32]    = r.tol;
    assign src0_o[b*32 +: 32]   = r.src0;
    assign src1_o[b*32 +: 32]   = r.src1;
    assign imask_o[b*32 +: 32]  = r.imask;
  end

  gpio_idx_pending #(.NPIN(NPIN), .CNT_W(CNT_W)) u_pend (
    .clk_i, .rst_ni, .set_i(set_all), .clr_i(clr_all),
    .pending_o, .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= dec_err;
  end
  assign err_o = err_q;
endmodule

// File: rtl/gpio_idx_writer_chk.sv
module gpio_idx_writer_chk #(
  parameter int                  NBANK    = 2,
  parameter int                  ADDR_W   = 12,
  parameter logic [11:0]         IDX_ADDR = 12'h2AC,
  parameter logic [NBANK*32-1:0] IN_CAP   = '1,
  parameter logic [NBANK*32-1:0] OUT_CAP  = '1,
  parameter int                  CNT_W    = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [NBANK*32-1:0] int_set_i,
  input logic [NBANK*32-1:0] data_o,
  input logic [NBANK*32-1:0] dir_o,
  input logic [NBANK*32-1:0] src0_o,
  input logic [NBANK*32-1:0] src1_o,
  input logic [NBANK*32-1:0] imask_o,
  input logic [CNT_W-1:0]    pending_o,
  input logic                irq_o,
  input logic                err_o
);
  localparam logic [NBANK*32-1:0] GRP_BASE = {(NBANK*4){8'h01}};

  // R1
  idle_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_addr_i != ADDR_W'(IDX_ADDR)) |=>
      ($stable(data_o) && $stable(dir_o) && $stable(src0_o) && $stable(imask_o)));

  // R10
  err_needs_index_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i && wr_addr_i == ADDR_W'(IDX_ADDR)));

  // R3
  data_out_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o & ~OUT_CAP) == '0);

  // R8
  imask_in_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_o & ~IN_CAP) == '0);

  // R9
  src_group_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src0_o | src1_o) & ~GRP_BASE) == '0);

  // R13
  pending_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o > $past(pending_o)) |-> $past(|int_set_i));

  // R13
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|int_set_i));
endmodule

bind gpio_idx_writer gpio_idx_writer_chk #(
  .NBANK(NBANK), .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR),
  .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .int_set_i,
  .data_o, .dir_o, .src0_o, .src1_o, .imask_o,
  .pending_o, .irq_o, .err_o
);

// File: tb/gpio_idx_writer_test.sv
module gpio_idx_writer_test;
  localparam int          NBANK = 2;
  localparam int          NPIN  = 64;
  localparam int          CNT_W = 7;
  localparam logic [11:0] IDX   = 12'h2AC;
  localparam logic [63:0] INC   = {32'h00FF_FFFF, 32'hFFFF_FF0F};
  localparam logic [63:0] OUTC  = {32'h0F0F_FFFF, 32'hFFFF_F0FF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NPIN-1:0] iset = '0;
  logic [NPIN-1:0] data, dir, en, s0, s1, s2, st, d1, d2, tol, c0, c1, im;
  logic [CNT_W-1:0] pend;
  logic irq, err;

  always #4 clk = ~clk;

  gpio_idx_writer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
    .int_set_i(iset), .data_o(data), .dir_o(dir), .int_en_o(en), .sens0_o(s0),
    .sens1_o(s1), .sens2_o(s2), .status_o(st), .deb1_o(d1), .deb2_o(d2), .tol_o(tol),
    .src0_o(c0), .src1_o(c1), .imask_o(im), .pending_o(pend), .irq_o(irq), .err_o(err)
  );

  int checks = 0, fails = 0;
  logic [NPIN-1:0] m_data = '0, m_dir = '0, m_en = '0, m_s0 = '0, m_s1 = '0, m_s2 = '0;
  logic [NPIN-1:0] m_st = '0, m_d1 = '0, m_d2 = '0, m_tol = '0, m_c0 = '0, m_c1 = '0, m_im = '0;
  int m_pend = 0;
  logic m_err = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3", "data", data, m_data);
    chk("R4", "dir", dir, m_dir);
    chk("R5", "int_en", en, m_en);
    chk("R5", "sens0", s0, m_s0);
    chk("R5", "sens1", s1, m_s1);
    chk("R5", "sens2", s2, m_s2);
    chk("R6", "status", st, m_st);
    chk("R7", "deb1", d1, m_d1);
    chk("R7", "deb2", d2, m_d2);
    chk("R7", "tol", tol, m_tol);
    chk("R9", "src0", c0, m_c0);
    chk("R9", "src1", c1, m_c1);
    chk("R8", "imask", im, m_im);
    chk("R6", "pending", 64'(pend), 64'(m_pend));
    chk("R13", "irq", 64'(irq), 64'(m_pend != 0));
    chk("R10", "err", 64'(err), 64'(m_err));
  endtask

  // R2 decode model
  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    int num, typ, bank, base, idx, gi;
    logic [4:0] v;
    logic hit, bad_t, bad_b;
    num = int'(d[7:0]); typ = int'(d[19:16]); v = d[24:20];
    bank = num / 32; base = bank * 32; idx = num; gi = base + ((num % 32) / 8) * 8;
    hit = (a == IDX); bad_t = typ > 6; bad_b = bank >= NBANK;
    m_err = hit && (bad_t || bad_b || d[12]);
    if (hit && !bad_t && !bad_b) begin
      case (typ)
        0: begin
          m_data[idx] = v[0];
          for (int j = base; j < base + 32; j++) m_data[j] = m_data[j] & OUTC[j];
        end
        1: begin
          m_dir[idx] = v[0];
          for (int j = base; j < base + 32; j++) m_dir[j] = (m_dir[j] | ~INC[j]) & OUTC[j];
        end
        2: begin
          m_en[idx] = v[0]; m_s0[idx] = v[1]; m_s1[idx] = v[2]; m_s2[idx] = v[3];
          if (v[4] && m_st[idx]) begin
            m_st[idx] = 1'b0;
            if (m_pend > 0) m_pend--;
          end
        end
        3: begin m_d1[idx] = v[0]; m_d2[idx] = v[1]; end
        4: m_tol[idx] = v[0];
        5: begin m_c0[gi] = v[0]; m_c1[gi] = v[1]; end
        6: m_im[idx] = v[0] & INC[idx];
        default: ;
      endcase
    end
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic do_set(input logic [NPIN-1:0] s);
    logic [NPIN-1:0] nw;
    nw = s & m_en & ~m_st;
    m_st = m_st | nw;
    m_pend += $countones(nw);
    m_err = 1'b0;
    iset = s;
    @(negedge clk);
    iset = '0;
    check_all();
  endtask

  function automatic logic [31:0] cmd(input int num, input int typ, input logic [4:0] v, input logic c);
    return {7'b0, v, 4'(typ), 3'b0, c, 4'b0, 8'(num)};
  endfunction

  initial begin
    logic [4:0] pats[4];
    pats[0] = 5'h1F; pats[1] = 5'h00; pats[2] = 5'h15; pats[3] = 5'h0A;
    repeat (3) @(negedge clk);
    check_all();                         // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // R3 R4 R5 R7 R8 R9 sweep over every pin, valid type and pattern
    for (int p = 0; p < NPIN; p++) begin
      for (int t = 0; t <= 6; t++)
        for (int k = 0; k < 4; k++) do_wr(IDX, cmd(p, t, pats[k], 1'b0));
      do_wr(IDX, cmd(p, 2, 5'h01, 1'b0));   // R13 enable before event
      do_set('1);
      do_wr(IDX, cmd((p * 7) % NPIN, 2, 5'h11, 1'b0));  // R6 clear, possibly unset bit
      do_wr(IDX, cmd(p, 2, 5'h10, 1'b0));   // R6 clear and disable
      do_wr(IDX, cmd(p, 2, 5'h10, 1'b0));   // R6 clear of already-clear bit
    end
    do_wr(IDX, cmd(3, 0, 5'h01, 1'b0));
    do_wr(IDX, cmd(40, 1, 5'h01, 1'b0));
    // R12 out-of-range pins
    for (int p = NPIN; p < 256; p++) do_wr(IDX, cmd(p, p % 7, 5'h1F, 1'b0));
    // R10 reserved and unlisted types
    for (int t = 7; t < 16; t++)
      for (int p = 0; p < NPIN; p += 9) do_wr(IDX, cmd(p, t, 5'h1F, 1'b0));
    // R11 command bit still applies
    for (int t = 0; t <= 6; t++) do_wr(IDX, cmd(5 + t * 8, t, 5'h1F, 1'b1));
    // R1 foreign addresses
    do_wr(12'h2A8, cmd(6, 0, 5'h00, 1'b0));
    do_wr(12'h2B0, cmd(6, 1, 5'h00, 1'b0));
    do_wr(12'h000, cmd(13, 6, 5'h00, 1'b0));
    do_wr(12'hAAC, cmd(13, 5, 5'h00, 1'b0));
    // R13 multi-bit events and irq drop to zero
    for (int p = 0; p < NPIN; p += 5) do_wr(IDX, cmd(p, 2, 5'h01, 1'b0));
    do_set(64'h5555_AAAA_0F0F_F0F0);
    do_set('1);
    for (int p = 0; p < NPIN; p++) do_wr(IDX, cmd(p, 2, 5'h10, 1'b0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule